// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers up to sixteen level-sensitive interrupt request lines plus one non-maskable input. It picks the most urgent request and offers its vector to a processor core. Each line has an enable bit and a 4-bit urgency value, where a smaller number is more urgent. A global threshold can suppress every line at or below a chosen urgency. The controller keeps a stack of the urgency levels of handlers currently in service. A new request is offered only when it is strictly more urgent than the handler on top of that stack, so handlers nest up to one level per urgency value plus one level for the non-maskable input.

The core side uses five signals. The controller raises an entry request together with a vector. The core acknowledges the entry, reports while it is saving context, and pulses an exit strobe when a handler returns.

Two shortcuts keep switching overhead low:
- **Tail chaining.** When an exit leaves a pending request that beats the context below it, the next entry is offered in the same cycle as the exit. It is flagged so the core can skip the restore.
- **Late arrival.** If a more urgent request appears while context saving is under way, the offered vector is swapped for the new one. The displaced request stays pending.

Configuration goes through a single write port.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After a synchronous reset, `entry_req` and `entry_chain` are low, no request is pending, every line is disabled with urgency 0, the threshold is 0 and no handler is in service.
- R2: A configuration write takes effect on the clock edge where `cfg_we` is high. The `cfg_sel` field selects the target:
  - 0 enables line `cfg_idx` when any of `cfg_wdata[3:0]` is 1, and disables it otherwise.
  - 1 loads `cfg_wdata[7:4]` as the urgency of line `cfg_idx`.
  - 2 loads `cfg_wdata[7:4]` as the threshold.
  - 3 sets the pending bit of line `cfg_idx` directly.
- R3: A high level on a line that is not in service sets its pending bit, and an acknowledged entry of that line clears it. A line that is still high after its handler exits becomes pending on the following edge and is offered one edge later.
- R4: Among enabled, unmasked pending lines, the smallest urgency value wins, and on a tie the lowest line number wins. A disabled line is never offered.
- R5: With a nonzero threshold T, lines whose urgency is equal to or greater than T are never offered. A threshold of 0 masks nothing.
- R6: The non-maskable input ignores enables and the threshold, and it beats every line. Its vector is 16, with bit 4 set and bits 3:0 zero. A line's vector is its line number with bit 4 clear.
- R7: From idle, a line raised before edge k gives `entry_req` high with its vector after edge k+1. `entry_req` stays high until the edge where `entry_ack` is seen.
- R8: While a handler is in service, a request of equal or lower urgency is not offered, and a strictly more urgent one is offered.
- R9: When an exit strobe pops the stack and a pending request beats the new top of the stack, `entry_req` and `entry_chain` are high after that same edge. On an exit that leaves nothing eligible, `entry_req` stays low.
- R10: While `entry_req` is high and `stacking` is high, a strictly more urgent request replaces the offered vector. A less urgent one does not. The displaced request stays pending and is offered later.
- R11: The stack holds 17 levels. Exits unwind it in last-in, first-out order, each exit releasing the handler entered most recently.
- R12: An exit strobe while `entry_req` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 16 | Level-sensitive request lines |
| nmi_in | input | 1 | Non-maskable request |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target select (see R2) |
| cfg_idx | input | 4 | Line number for per-line writes |
| cfg_wdata | input | 8 | Write data |
| entry_ack | input | 1 | Core accepts the offered entry |
| stacking | input | 1 | Core is saving context for the offered entry |
| hnd_exit | input | 1 | Handler return strobe |
| entry_req | output | 1 | Entry offered to the core |
| entry_vec | output | 5 | Offered vector |
| entry_chain | output | 1 | Offered entry is a tail-chained one |

## Verification
A raised request line passes through the pending register and then the entry register, so its entry is checked two edges later. A software pend or threshold write skips the line sampling and is checked one edge after the write edge. A tail-chained entry is checked at the very edge of the exit strobe. A late-arrival swap is due two edges after the urgent line rises, and a re-pend after exit is due two edges after the exit. The bench drives inputs and samples outputs on falling edges, advancing an exact number of rising edges for each case. Every "nothing offered" check is therefore taken at the cycle where a wrong design would already show a request.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

  typedef enum logic [1:0] {
    CFG_ENABLE = 2'd0,
    CFG_PRIO   = 2'd1,
    CFG_MASK   = 2'd2,
    CFG_PEND   = 2'd3
  } cfg_sel_e;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_nest_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int PRIO_W    = 4,
  parameter int LINE_W    = 4,
  parameter int CFG_W     = 8
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               cfg_we,
  input  logic [1:0]                         cfg_sel,
  input  logic [LINE_W-1:0]                  cfg_idx,
  input  logic [CFG_W-1:0]                   cfg_wdata,
  output logic [NUM_LINES-1:0]               en_q,
  output logic [NUM_LINES-1:0][PRIO_W-1:0]   prio_q,
  output logic [PRIO_W-1:0]                  mask_q,
  output logic [NUM_LINES-1:0]               swpend
);

  localparam int LOW_W = CFG_W - PRIO_W;

  cfg_sel_e          sel;
  logic [PRIO_W-1:0] field_hi;
  logic              low_set;
  logic              idx_ok;

  assign sel      = cfg_sel_e'(cfg_sel);
  assign field_hi = cfg_wdata[CFG_W-1 -: PRIO_W];
  assign low_set  = |cfg_wdata[LOW_W-1:0];
  assign idx_ok   = (int'(cfg_idx) < NUM_LINES);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      prio_q <= '0;
      mask_q <= '0;
    end else if (cfg_we) begin
      case (sel)
        CFG_ENABLE: if (idx_ok) en_q[cfg_idx]   <= low_set;
        CFG_PRIO:   if (idx_ok) prio_q[cfg_idx] <= field_hi;
        CFG_MASK:   mask_q <= field_hi;
        default:    ;
      endcase
    end
  end

  always_comb begin
    swpend = '0;
    if (cfg_we && sel == CFG_PEND && idx_ok) swpend[cfg_idx] = 1'b1;
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_LINES = 16,
  parameter int PRIO_W    = 4,
  parameter int LINE_W    = 4,
  parameter int RANK_W    = PRIO_W + 1,
  parameter int VEC_W     = LINE_W + 1
) (
  input  logic [NUM_LINES-1:0]             pend,
  input  logic [NUM_LINES-1:0]             en,
  input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]                mask,
  input  logic                             nmi_pend,
  output logic                             win_valid,
  output logic [RANK_W-1:0]                win_rank,
  output logic [VEC_W-1:0]                 win_vec
);

  localparam logic [RANK_W-1:0] IDLE_RANK = RANK_W'((1 << PRIO_W) + 1);

  logic [NUM_LINES-1:0] elig;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_elig
    assign elig[g] = pend[g] && en[g] && ((mask == '0) || (prio[g] < mask));
  end

  always_comb begin
    win_valid = 1'b0;
    win_rank  = IDLE_RANK;
    win_vec   = '0;
    if (nmi_pend) begin
      win_valid = 1'b1;
      win_rank  = '0;
      win_vec   = VEC_W'(1 << LINE_W);
    end else begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (elig[i] && (RANK_W'(prio[i]) + RANK_W'(1) < win_rank)) begin
          win_valid = 1'b1;
          win_rank  = RANK_W'(prio[i]) + RANK_W'(1);
          win_vec   = VEC_W'(i);
        end
      end
    end
  end

endmodule

// File: rtl/irq_active_stack.sv
module irq_active_stack #(
  parameter int PRIO_W = 4,
  parameter int RANK_W = PRIO_W + 1,
  parameter int VEC_W  = 5,
  parameter int DEPTH  = (1 << PRIO_W) + 1,
  parameter int SP_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [RANK_W-1:0] push_rank,
  input  logic [VEC_W-1:0]  push_vec,
  input  logic              pop,
  output logic [RANK_W-1:0] top_rank,
  output logic [VEC_W-1:0]  top_vec,
  output logic [RANK_W-1:0] below_rank,
  output logic [SP_W-1:0]   depth
);

  localparam logic [RANK_W-1:0] IDLE_RANK = RANK_W'((1 << PRIO_W) + 1);
  localparam int ENT_W = RANK_W + VEC_W;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [SP_W-1:0]  sp_q;
  logic [ENT_W-1:0] top_ent;
  logic [ENT_W-1:0] below_ent;

  always_ff @(posedge clk) begin
    if (push) mem[sp_q] <= {push_rank, push_vec};
  end

  always_ff @(posedge clk) begin
    if (rst)       sp_q <= '0;
    else if (push) sp_q <= sp_q + SP_W'(1);
    else if (pop)  sp_q <= sp_q - SP_W'(1);
  end

  assign top_ent   = (sp_q >= SP_W'(1)) ? mem[sp_q - SP_W'(1)] : '0;
  assign below_ent = (sp_q >= SP_W'(2)) ? mem[sp_q - SP_W'(2)] : '0;
  assign top_rank   = (sp_q == '0) ? IDLE_RANK : top_ent[ENT_W-1 -: RANK_W];
  assign top_vec    = top_ent[VEC_W-1:0];
  assign below_rank = (sp_q < SP_W'(2)) ? IDLE_RANK : below_ent[ENT_W-1 -: RANK_W];
  assign depth      = sp_q;

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
    push |-> (sp_q < SP_W'(DEPTH)));

  p_pop_nonempty_r11: assert property (@(posedge clk) disable iff (rst)
    pop |-> (sp_q != '0));

  p_push_urgent_r8: assert property (@(posedge clk) disable iff (rst)
    push |-> (push_rank < top_rank));

  p_push_pop_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(push && pop));

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int PRIO_W    = 4,
  parameter int CFG_W     = 8,
  parameter int LINE_W    = $clog2(NUM_LINES),
  parameter int VEC_W     = LINE_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 nmi_in,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_sel,
  input  logic [LINE_W-1:0]    cfg_idx,
  input  logic [CFG_W-1:0]     cfg_wdata,
  input  logic                 entry_ack,
  input  logic                 stacking,
  input  logic                 hnd_exit,
  output logic                 entry_req,
  output logic [VEC_W-1:0]     entry_vec,
  output logic                 entry_chain
);

  localparam int RANK_W = PRIO_W + 1;
  localparam int DEPTH  = (1 << PRIO_W) + 1;
  localparam int SP_W   = $clog2(DEPTH + 1);

  logic [NUM_LINES-1:0]             en_q;
  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_q;
  logic [PRIO_W-1:0]                mask_q;
  logic [NUM_LINES-1:0]             swpend;

  logic [NUM_LINES-1:0] pend_vec;
  logic [NUM_LINES-1:0] act_vec;
  logic                 nmi_pend_q;
  logic                 nmi_act_q;

  logic              win_valid;
  logic [RANK_W-1:0] win_rank;
  logic [VEC_W-1:0]  win_vec;

  logic [RANK_W-1:0] top_rank;
  logic [VEC_W-1:0]  top_vec;
  logic [RANK_W-1:0] below_rank;
  logic [SP_W-1:0]   depth;

  logic              entry_req_q;
  logic [VEC_W-1:0]  entry_vec_q;
  logic              entry_chain_q;
  logic [RANK_W-1:0] offer_rank_q;

  logic              ack_fire;
  logic              pop;
  logic [RANK_W-1:0] eff_rank;
  logic              take;
  logic              late;
  logic              ack_is_nmi;
  logic              pop_is_nmi;

  irq_cfg_regs #(
    .NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .LINE_W(LINE_W), .CFG_W(CFG_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .en_q(en_q), .prio_q(prio_q), .mask_q(mask_q),
    .swpend(swpend)
  );

  irq_arbiter #(
    .NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .LINE_W(LINE_W),
    .RANK_W(RANK_W), .VEC_W(VEC_W)
  ) u_arb (
    .pend(pend_vec), .en(en_q), .prio(prio_q), .mask(mask_q),
    .nmi_pend(nmi_pend_q), .win_valid(win_valid), .win_rank(win_rank),
    .win_vec(win_vec)
  );

  irq_active_stack #(
    .PRIO_W(PRIO_W), .RANK_W(RANK_W), .VEC_W(VEC_W), .DEPTH(DEPTH), .SP_W(SP_W)
  ) u_stack (
    .clk(clk), .rst(rst), .push(ack_fire), .push_rank(offer_rank_q),
    .push_vec(entry_vec_q), .pop(pop), .top_rank(top_rank), .top_vec(top_vec),
    .below_rank(below_rank), .depth(depth)
  );

  // Core handshake decode
  assign ack_fire   = entry_req_q && entry_ack;
  assign pop        = !entry_req_q && hnd_exit;
  assign eff_rank   = pop ? below_rank : top_rank;
  assign take       = !entry_req_q && win_valid && (win_rank < eff_rank);
  assign late       = entry_req_q && !entry_ack && stacking && win_valid &&
                      (win_rank < offer_rank_q);
  assign ack_is_nmi = ack_fire && entry_vec_q[LINE_W];
  assign pop_is_nmi = pop && top_vec[LINE_W];

  // Per-line pending and in-service bits
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic pend_r;
    logic act_r;
    logic clr;
    logic rel;

    assign clr = ack_fire && !entry_vec_q[LINE_W] &&
                 (entry_vec_q[LINE_W-1:0] == LINE_W'(g));
    assign rel = pop && !top_vec[LINE_W] && (top_vec[LINE_W-1:0] == LINE_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_r <= 1'b0;
        act_r  <= 1'b0;
      end else begin
        pend_r <= (pend_r || (irq_in[g] && !act_r) || swpend[g]) && !clr;
        if (clr)      act_r <= 1'b1;
        else if (rel) act_r <= 1'b0;
      end
    end

    assign pend_vec[g] = pend_r;
    assign act_vec[g]  = act_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_pend_q <= 1'b0;
      nmi_act_q  <= 1'b0;
    end else begin
      nmi_pend_q <= (nmi_pend_q || (nmi_in && !nmi_act_q)) && !ack_is_nmi;
      if (ack_is_nmi)      nmi_act_q <= 1'b1;
      else if (pop_is_nmi) nmi_act_q <= 1'b0;
    end
  end

  // Entry offer register
  always_ff @(posedge clk) begin
    if (rst) begin
      entry_req_q   <= 1'b0;
      entry_vec_q   <= '0;
      entry_chain_q <= 1'b0;
      offer_rank_q  <= '0;
    end else if (take) begin
      entry_req_q   <= 1'b1;
      entry_vec_q   <= win_vec;
      entry_chain_q <= pop;
      offer_rank_q  <= win_rank;
    end else if (ack_fire) begin
      entry_req_q   <= 1'b0;
      entry_chain_q <= 1'b0;
    end else if (late) begin
      entry_vec_q  <= win_vec;
      offer_rank_q <= win_rank;
    end
  end

  assign entry_req   = entry_req_q;
  assign entry_vec   = entry_vec_q;
  assign entry_chain = entry_chain_q;

  p_req_held_r7: assert property (@(posedge clk) disable iff (rst)
    (entry_req_q && !entry_ack) |=> entry_req_q);

  p_swap_urgent_r10: assert property (@(posedge clk) disable iff (rst)
    (entry_req_q && !entry_ack) |=> (offer_rank_q <= $past(offer_rank_q)));

  p_exit_ignored_r12: assert property (@(posedge clk) disable iff (rst)
    (entry_req_q && hnd_exit && !entry_ack) |=> (depth == $past(depth)));

  p_nmi_first_r6: assert property (@(posedge clk) disable iff (rst)
    (nmi_pend_q && !nmi_act_q && !entry_req_q) |=> (entry_req_q && entry_vec_q[LINE_W]));

  p_mask_r5: assert property (@(posedge clk) disable iff (rst)
    (take && !win_vec[LINE_W] && (mask_q != '0)) |->
      (prio_q[win_vec[LINE_W-1:0]] < mask_q));

  p_line_once_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pend_vec & act_vec & ~swpend) || (pend_vec & act_vec) == '0);

endmodule

// File: tb/tb_irq_nest_ctrl.sv
module tb_irq_nest_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq_in = '0;
  logic        nmi_in = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [3:0]  cfg_idx = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        entry_ack = 1'b0;
  logic        stacking = 1'b0;
  logic        hnd_exit = 1'b0;
  logic        entry_req;
  logic [4:0]  entry_vec;
  logic        entry_chain;

  int n_cmp = 0;
  int n_bad = 0;

  irq_nest_ctrl dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .nmi_in(nmi_in), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .entry_ack(entry_ack), .stacking(stacking), .hnd_exit(hnd_exit),
    .entry_req(entry_req), .entry_vec(entry_vec), .entry_chain(entry_chain)
  );

  always #5 clk = ~clk;

  // {line pattern, expected request, expected vector}; urgency of line i is 7-(i>>1)
  localparam int NTAB = 8;
  localparam logic [21:0] VTAB [NTAB] = '{
    {16'hC000, 1'b1, 5'd14},
    {16'h8001, 1'b1, 5'd15},
    {16'h0003, 1'b1, 5'd0},
    {16'h0030, 1'b1, 5'd4},
    {16'h0128, 1'b1, 5'd8},
    {16'h0000, 1'b0, 5'd0},
    {16'h0A00, 1'b1, 5'd11},
    {16'h6000, 1'b1, 5'd14}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [3:0] idx, input logic [7:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_wdata = d;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; irq_in = '0; nmi_in = 1'b0; entry_ack = 1'b0;
    stacking = 1'b0; hnd_exit = 1'b0;
    tick(2);
    rst = 1'b0;
  endtask

  task automatic ack();
    entry_ack = 1'b1;
    tick(1);
    entry_ack = 1'b0;
  endtask

  task automatic exitp();
    hnd_exit = 1'b1;
    tick(1);
    hnd_exit = 1'b0;
  endtask

  task automatic cfg_table();
    for (int i = 0; i < 16; i++) begin
      wr(2'd0, 4'(i), 8'h01);
      wr(2'd1, 4'(i), 8'((7 - (i >> 1)) << 4));
    end
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    // R1: reset state
    chk("R1 entry_req after reset", entry_req, 0);
    chk("R1 entry_chain after reset", entry_chain, 0);
    // R1/R4: lines raised with everything disabled are not offered
    irq_in = 16'hFFFF;
    tick(3);
    chk("R4 disabled lines not offered", entry_req, 0);
    // R6: non-maskable input ignores enables
    nmi_in = 1'b1;
    tick(2);
    chk("R6 nmi offered", entry_req, 1);
    chk("R6 nmi vector", entry_vec, 16);
    ack();
    nmi_in = 1'b0;
    irq_in = '0;
    exitp();
    chk("R9 exit with nothing eligible", entry_req, 0);

    // R4: arbitration vector table
    for (int t = 0; t < NTAB; t++) begin
      do_reset();
      cfg_table();
      irq_in = VTAB[t][21:6];
      tick(2);
      chk("R4 table request", entry_req, int'(VTAB[t][5]));
      if (VTAB[t][5]) chk("R4 table vector", entry_vec, int'(VTAB[t][4:0]));
      irq_in = '0;
    end

    // R5: threshold
    do_reset();
    cfg_table();
    wr(2'd2, 4'd0, 8'h10);
    irq_in = 16'h3FFF;
    tick(3);
    chk("R5 threshold 1 blocks urgency >=1", entry_req, 0);
    do_reset();
    cfg_table();
    wr(2'd2, 4'd0, 8'h20);
    irq_in = 16'h0C00;
    tick(3);
    chk("R5 urgency equal to threshold blocked", entry_req, 0);
    wr(2'd2, 4'd0, 8'h00);
    tick(1);
    chk("R5 threshold 0 masks nothing", entry_req, 1);
    chk("R5 vector after unmask", entry_vec, 10);

    // R6: nmi beats the most urgent line, then tail chain to it
    do_reset();
    cfg_table();
    irq_in = 16'hC000;
    nmi_in = 1'b1;
    tick(2);
    chk("R6 nmi beats line", entry_vec, 16);
    ack();
    nmi_in = 1'b0;
    exitp();
    chk("R9 chain after nmi request", entry_req, 1);
    chk("R9 chain after nmi vector", entry_vec, 14);
    chk("R9 chain flag", entry_chain, 1);
    do_reset();
    wr(2'd2, 4'd0, 8'h10);
    nmi_in = 1'b1;
    tick(2);
    chk("R6 nmi ignores threshold", entry_vec, 16);
    nmi_in = 1'b0;

    // R8/R9/R3: nesting, tail chain, re-pend after exit
    do_reset();
    cfg_table();
    irq_in[4] = 1'b1;
    tick(2);
    chk("R7 entry two edges after line", entry_req, 1);
    chk("R7 vector line 4", entry_vec, 4);
    ack();
    chk("R7 request drops on ack", entry_req, 0);
    irq_in[5] = 1'b1;
    tick(3);
    chk("R8 equal urgency not offered", entry_req, 0);
    irq_in[8] = 1'b1;
    tick(2);
    chk("R8 more urgent preempts", entry_req, 1);
    chk("R8 preempting vector", entry_vec, 8);
    ack();
    irq_in[8] = 1'b0;
    exitp();
    chk("R9 no chain at equal level", entry_req, 0);
    irq_in[4] = 1'b0;
    exitp();
    chk("R9 tail chain request", entry_req, 1);
    chk("R9 tail chain vector", entry_vec, 5);
    chk("R9 tail chain flag", entry_chain, 1);
    ack();
    exitp();
    chk("R3 no request at exit edge", entry_req, 0);
    tick(1);
    chk("R3 no request while re-pending", entry_req, 0);
    tick(1);
    chk("R3 still-high line re-offered", entry_req, 1);
    chk("R3 re-offered vector", entry_vec, 5);
    chk("R3 re-offer is not chained", entry_chain, 0);
    irq_in[5] = 1'b0;
    ack();
    exitp();
    tick(2);
    chk("R3 cleared after ack", entry_req, 0);

    // R10: late arrival
    do_reset();
    cfg_table();
    irq_in[0] = 1'b1;
    tick(2);
    chk("R10 first offer", entry_vec, 0);
    stacking = 1'b1;
    irq_in[14] = 1'b1;
    tick(2);
    chk("R10 request kept during swap", entry_req, 1);
    chk("R10 vector replaced", entry_vec, 14);
    ack();
    stacking = 1'b0;
    irq_in = '0;
    exitp();
    chk("R10 displaced request chained", entry_req, 1);
    chk("R10 displaced vector", entry_vec, 0);
    ack();
    exitp();
    tick(1);
    chk("R10 idle afterwards", entry_req, 0);
    do_reset();
    cfg_table();
    irq_in[8] = 1'b1;
    tick(2);
    stacking = 1'b1;
    irq_in[0] = 1'b1;
    tick(2);
    chk("R10 less urgent does not swap", entry_vec, 8);
    stacking = 1'b0;

    // R12: exit during outstanding entry
    do_reset();
    cfg_table();
    irq_in[4] = 1'b1;
    tick(2);
    exitp();
    chk("R12 exit ignored request", entry_req, 1);
    chk("R12 exit ignored vector", entry_vec, 4);
    ack();
    irq_in[4] = 1'b0;
    exitp();
    tick(2);
    chk("R12 idle after real exit", entry_req, 0);
    irq_in[4] = 1'b1;
    tick(2);
    chk("R12 line accepted again", entry_vec, 4);
    irq_in[4] = 1'b0;

    // R2: software pend
    do_reset();
    cfg_table();
    wr(2'd3, 4'd9, 8'h00);
    tick(1);
    chk("R2 software pend request", entry_req, 1);
    chk("R2 software pend vector", entry_vec, 9);

    // R11: full depth nesting and LIFO unwind
    do_reset();
    for (int i = 0; i < 16; i++) begin
      wr(2'd0, 4'(i), 8'h01);
      wr(2'd1, 4'(i), 8'((15 - i) << 4));
    end
    for (int i = 0; i < 16; i++) begin
      irq_in[i] = 1'b1;
      tick(2);
      chk("R11 nested entry", entry_vec, i);
      ack();
    end
    nmi_in = 1'b1;
    tick(2);
    chk("R11 nmi on top of full stack", entry_vec, 16);
    ack();
    nmi_in = 1'b0;
    exitp();
    chk("R11 unwind nmi", entry_req, 0);
    for (int i = 15; i >= 0; i--) begin
      irq_in[i] = 1'b0;
      exitp();
      chk("R11 unwind line", entry_req, 0);
    end
    tick(2);
    chk("R11 idle after unwind", entry_req, 0);
    irq_in[7] = 1'b1;
    tick(2);
    chk("R11 stack empty, lowest level accepted", entry_vec, 7);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL R7 watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule